// File: doc/BRIEF.md
# Soft-Start Fault Sequencer

This block supervises start-up and fault recovery for a phase-shifted bridge controller. It owns a digital soft-start level, a counter that also serves as a ceiling on the control command. Supply, reference, disable, overcurrent and no-load conditions arrive as flags that are already digital. From them the block derives an output-enable for the bridge drivers and the clamped command. The analog charge and discharge currents are modelled as counter step sizes.

Faults come in two kinds. A supply undervoltage, a bad reference or an external disable request is a hard shutdown: the level drops to zero on the next clock. An overcurrent starts a controlled soft stop instead. The level falls at ten times the ramp-up rate until it drops below a floor, and then a full soft start follows. In every case the output-enable drops in the same cycle as the fault flag. The supply check has hysteresis: separate flags mark the start threshold and the minimum operating level.

Top module: `ssq_top`

## Requirements
- R1: After reset the state is LOCKOUT (code 0 on `state_o`), the level is 0, the clamped command is 0 and `drive_en_o` is low.
- R2: The supply check has hysteresis. LOCKOUT is left only after `vdd_start_i` has been seen high. Once left, it is not re-entered until `vdd_low_i` is high. When `vdd_low_i` is high it wins over `vdd_start_i`.
- R3: A high `vdd_low_i` takes priority over every other input. On the next clock the state becomes LOCKOUT (0) and the level becomes 0.
- R4: With the supply good, a high `ref_bad_i` makes the state DISABLED (code 1) and the level 0 on the next clock.
- R5: With the supply good and the reference good, a high `ext_dis_i` makes the state DISABLED (1) and the level 0 on the next clock.
- R6: `drive_en_o` goes low in the same cycle that any of `vdd_low_i`, `ref_bad_i`, `ext_dis_i` or `oc_i` goes high, without waiting for a clock edge.
- R7: With no fault present, the state leaves LOCKOUT or DISABLED for SOFT_START (code 2) with the level at 0. In SOFT_START the level rises by UP_STEP on each clock and stops at 2^W-1. One clock after the level reaches 2^W-1, the state becomes RUN (code 3).
- R8: A high `oc_i` in SOFT_START or RUN leads to SOFT_STOP (code 4) on the next clock, with the level held for that clock. In SOFT_STOP the level falls by UP_STEP*DN_MULT on each clock and stops at 0. Further overcurrent is ignored during SOFT_STOP.
- R9: In SOFT_STOP, once the level is below FLOOR, the next clock moves the state to SOFT_START and adds UP_STEP to the level.
- R10: `cmd_o` equals the smaller of `cmd_i` and the level, in every state.
- R11: The no-load flag follows `cmd_o` with hysteresis. It clears on the clock after `cmd_o` falls below NL_OFF and sets on the clock after `cmd_o` rises above NL_ON; between the two it keeps its value. While the flag is clear, `drive_en_o` is low.
- R12: `drive_en_o` is high only in SOFT_START or RUN, and then only when the supply is good, no fault flag is set and the no-load flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| vdd_start_i | input | 1 | Supply above start threshold |
| vdd_low_i | input | 1 | Supply below minimum operating level |
| ref_bad_i | input | 1 | Reference below its good threshold |
| ext_dis_i | input | 1 | External disable request |
| oc_i | input | 1 | Overcurrent comparator tripped |
| cmd_i | input | W | Control command from the loop |
| cmd_o | output | W | Command clamped to the soft-start level |
| level_o | output | W | Soft-start level |
| drive_en_o | output | 1 | Bridge driver enable |
| state_o | output | 3 | Sequencer state code |

## Verification
The bench builds the block with W=10, UP_STEP=8 and DN_MULT=10. A full ramp then takes about 128 clocks and a soft stop from the top takes about a dozen. Because 1023 is not a multiple of 8, the last ramp step is clipped at the top. Because 1023 is not a multiple of 80, the soft stop crosses the floor of 102 between steps and ends at 63, so the bench sees the level step past the floor rather than land on it. With NL_OFF=102 and NL_ON=123, the no-load band is narrow enough to drive the command below, inside and above it with short sequences.

// File: rtl/ssq_pkg.sv
package ssq_pkg;
   typedef enum logic [2:0] {
      ST_LOCKOUT    = 3'd0,
      ST_DISABLED   = 3'd1,
      ST_SOFT_START = 3'd2,
      ST_RUN        = 3'd3,
      ST_SOFT_STOP  = 3'd4
   } ssq_state_e;

   typedef enum logic [1:0] {
      LV_HOLD  = 2'd0,
      LV_CLEAR = 2'd1,
      LV_UP    = 2'd2,
      LV_DOWN  = 2'd3
   } ssq_lvl_op_e;
endpackage

// File: rtl/ssq_uvlo.sv
module ssq_uvlo (
   input  logic clk,
   input  logic rst_n,
   input  logic vdd_start_i,
   input  logic vdd_low_i,
   output logic ok_now_o
);
   logic ok_q;

   always_comb begin
      if (vdd_low_i)        ok_now_o = 1'b0;
      else if (vdd_start_i) ok_now_o = 1'b1;
      else                  ok_now_o = ok_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ok_q <= 1'b0;
      else        ok_q <= ok_now_o;
   end

   // R2: without either flag the supply verdict keeps its value
   p_uv_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!vdd_low_i && !vdd_start_i) |=> (ok_q == $past(ok_q)));
endmodule

// File: rtl/ssq_level.sv
module ssq_level
   import ssq_pkg::*;
#(
   parameter int W        = 10,
   parameter int UP_STEP  = 1,
   parameter int DN_MULT  = 10
) (
   input  logic         clk,
   input  logic         rst_n,
   input  ssq_lvl_op_e  op_i,
   output logic [W-1:0] level_o,
   output logic         at_max_o
);
   localparam logic [W-1:0] LVL_MAX = {W{1'b1}};
   localparam logic [W-1:0] UP_V    = W'(UP_STEP);
   localparam logic [W-1:0] DN_V    = W'(UP_STEP * DN_MULT);

   logic [W-1:0] lvl_q, lvl_d;

   always_comb begin
      unique case (op_i)
         LV_CLEAR: lvl_d = '0;
         LV_UP:    lvl_d = (lvl_q > LVL_MAX - UP_V) ? LVL_MAX : lvl_q + UP_V;
         LV_DOWN:  lvl_d = (lvl_q < DN_V) ? '0 : lvl_q - DN_V;
         default:  lvl_d = lvl_q;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) lvl_q <= '0;
      else        lvl_q <= lvl_d;
   end

   assign level_o  = lvl_q;
   assign at_max_o = (lvl_q == LVL_MAX);

   // R7: a ramp step never moves the level down
   p_up_mono_r7: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(op_i) == LV_UP) |-> (lvl_q >= $past(lvl_q)));
   // R8: a soft-stop step never moves the level up
   p_dn_mono_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(op_i) == LV_DOWN) |-> (lvl_q <= $past(lvl_q)));
endmodule

// File: rtl/ssq_noload.sv
module ssq_noload #(
   parameter int W      = 10,
   parameter int NL_OFF = 102,
   parameter int NL_ON  = 123,
   parameter bit NL_EN  = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] cmd_i,
   output logic         load_ok_o
);
   localparam logic [W-1:0] OFF_V = W'(NL_OFF);
   localparam logic [W-1:0] ON_V  = W'(NL_ON);

   generate
      if (NL_EN) begin : g_detect
         logic ok_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)             ok_q <= 1'b0;
            else if (cmd_i < OFF_V) ok_q <= 1'b0;
            else if (cmd_i > ON_V)  ok_q <= 1'b1;
         end
         assign load_ok_o = ok_q;

         // R11: a command below the low threshold clears the flag next cycle
         p_nl_off_r11: assert property (@(posedge clk) disable iff (!rst_n)
            (cmd_i < OFF_V) |=> !load_ok_o);
         // R11: a command above the high threshold sets it next cycle
         p_nl_on_r11: assert property (@(posedge clk) disable iff (!rst_n)
            (cmd_i > ON_V) |=> load_ok_o);
      end else begin : g_bypass
         assign load_ok_o = 1'b1;
      end
   endgenerate
endmodule

// File: rtl/ssq_top.sv
module ssq_top
   import ssq_pkg::*;
#(
   parameter int W        = 10,
   parameter int UP_STEP  = 1,
   parameter int DN_MULT  = 10,
   parameter int FLOOR    = 102,
   parameter int NL_OFF   = 102,
   parameter int NL_ON    = 123,
   parameter bit NL_EN    = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         vdd_start_i,
   input  logic         vdd_low_i,
   input  logic         ref_bad_i,
   input  logic         ext_dis_i,
   input  logic         oc_i,
   input  logic [W-1:0] cmd_i,
   output logic [W-1:0] cmd_o,
   output logic [W-1:0] level_o,
   output logic         drive_en_o,
   output logic [2:0]   state_o
);
   localparam logic [W-1:0] FLOOR_V = W'(FLOOR);

   if (W < 4 || W > 24) begin : g_chk_w
      $error("ssq_top: W out of range");
   end
   if (UP_STEP < 1 || UP_STEP * DN_MULT >= (1 << W)) begin : g_chk_step
      $error("ssq_top: step sizes do not fit the level width");
   end
   if (DN_MULT < 1) begin : g_chk_mult
      $error("ssq_top: DN_MULT must be positive");
   end
   if (NL_ON < NL_OFF || NL_ON >= (1 << W)) begin : g_chk_nl
      $error("ssq_top: no-load thresholds inconsistent");
   end
   if (FLOOR < 1 || FLOOR >= (1 << W)) begin : g_chk_floor
      $error("ssq_top: FLOOR out of range");
   end

   ssq_state_e   st_q, st_d;
   ssq_lvl_op_e  lvl_op;
   logic         sup_ok;
   logic         lvl_max;
   logic         load_ok;
   logic [W-1:0] lvl;

   ssq_uvlo u_uvlo (
      .clk         (clk),
      .rst_n       (rst_n),
      .vdd_start_i (vdd_start_i),
      .vdd_low_i   (vdd_low_i),
      .ok_now_o    (sup_ok)
   );

   ssq_level #(.W(W), .UP_STEP(UP_STEP), .DN_MULT(DN_MULT)) u_level (
      .clk      (clk),
      .rst_n    (rst_n),
      .op_i     (lvl_op),
      .level_o  (lvl),
      .at_max_o (lvl_max)
   );

   assign cmd_o = (cmd_i < lvl) ? cmd_i : lvl;

   ssq_noload #(.W(W), .NL_OFF(NL_OFF), .NL_ON(NL_ON), .NL_EN(NL_EN)) u_noload (
      .clk       (clk),
      .rst_n     (rst_n),
      .cmd_i     (cmd_o),
      .load_ok_o (load_ok)
   );

   always_comb begin
      st_d   = st_q;
      lvl_op = LV_HOLD;
      if (!sup_ok) begin
         st_d   = ST_LOCKOUT;
         lvl_op = LV_CLEAR;
      end else if (ref_bad_i || ext_dis_i) begin
         st_d   = ST_DISABLED;
         lvl_op = LV_CLEAR;
      end else begin
         unique case (st_q)
            ST_LOCKOUT, ST_DISABLED: begin
               st_d   = ST_SOFT_START;
               lvl_op = LV_CLEAR;
            end
            ST_SOFT_START: begin
               if (oc_i)         st_d = ST_SOFT_STOP;
               else if (lvl_max) st_d = ST_RUN;
               else              lvl_op = LV_UP;
            end
            ST_RUN: begin
               if (oc_i) st_d = ST_SOFT_STOP;
            end
            ST_SOFT_STOP: begin
               if (lvl < FLOOR_V) begin
                  st_d   = ST_SOFT_START;
                  lvl_op = LV_UP;
               end else begin
                  lvl_op = LV_DOWN;
               end
            end
            default: begin
               st_d   = ST_LOCKOUT;
               lvl_op = LV_CLEAR;
            end
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st_q <= ST_LOCKOUT;
      else        st_q <= st_d;
   end

   assign drive_en_o = ((st_q == ST_SOFT_START) || (st_q == ST_RUN)) && sup_ok &&
                       !ref_bad_i && !ext_dis_i && !oc_i && load_ok;
   assign state_o    = st_q;
   assign level_o    = lvl;

   // R3: undervoltage wins over everything, next clock is lockout with zero level
   p_uv_prio_r3: assert property (@(posedge clk) disable iff (!rst_n)
      vdd_low_i |=> (state_o == ST_LOCKOUT && level_o == '0));
   // R4: bad reference with a good supply forces a hard disable
   p_ref_bad_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (sup_ok && ref_bad_i) |=> (state_o == ST_DISABLED && level_o == '0));
   // R6: any fault flag removes the driver enable at once
   p_fault_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (vdd_low_i || ref_bad_i || ext_dis_i || oc_i) |-> !drive_en_o);
   // R8: overcurrent while running leads to soft stop
   p_oc_stop_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (state_o == ST_RUN && oc_i && sup_ok && !ref_bad_i && !ext_dis_i)
      |=> (state_o == ST_SOFT_STOP));
   // R10: clamped command never exceeds either the level or the request
   p_clamp_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_o <= level_o) && (cmd_o <= cmd_i));
   // R12: enable only in the ramping or running states
   p_en_state_r12: assert property (@(posedge clk) disable iff (!rst_n)
      drive_en_o |-> (state_o == ST_SOFT_START || state_o == ST_RUN));
endmodule

// File: tb/tb_ssq_top.sv
module tb_ssq_top;
   localparam int W   = 10;
   localparam int UP  = 8;
   localparam int DNM = 10;
   localparam int DN  = UP * DNM;
   localparam int FLR = 102;
   localparam int MAXL = (1 << W) - 1;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         vdd_start = 1'b0, vdd_low = 1'b0, ref_bad = 1'b0, ext_dis = 1'b0, oc = 1'b0;
   logic [W-1:0] cmd = '0;
   logic [W-1:0] cmd_o, level;
   logic         drive_en;
   logic [2:0]   state;

   int checks = 0;
   int errors = 0;

   always #5 clk = ~clk;

   ssq_top #(.W(W), .UP_STEP(UP), .DN_MULT(DNM), .FLOOR(FLR),
             .NL_OFF(102), .NL_ON(123), .NL_EN(1'b1)) dut (
      .clk(clk), .rst_n(rst_n), .vdd_start_i(vdd_start), .vdd_low_i(vdd_low),
      .ref_bad_i(ref_bad), .ext_dis_i(ext_dis), .oc_i(oc), .cmd_i(cmd),
      .cmd_o(cmd_o), .level_o(level), .drive_en_o(drive_en), .state_o(state)
   );

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk);
      #2;
   endtask

   task automatic t_reset();
      check("R1 state", state, 0);
      check("R1 level", level, 0);
      check("R1 cmd_o", cmd_o, 0);
      check("R1 drive_en", drive_en, 0);
   endtask

   task automatic t_uvlo_release();
      for (int i = 0; i < 4; i++) step();
      check("R2 no start flag stays lockout", state, 0);
      vdd_start = 1'b1;
      step();
      vdd_start = 1'b0;
      check("R7 enter soft start", state, 2);
      check("R7 level zero at entry", level, 0);
   endtask

   task automatic t_ramp();
      int exp;
      exp = 0;
      cmd = 10'd500;
      #1;
      check("R11 drive off at zero level", drive_en, 0);
      check("R10 clamp at zero level", cmd_o, 0);
      while (exp < MAXL) begin
         step();
         exp = (exp + UP > MAXL) ? MAXL : exp + UP;
         check("R7 ramp step", level, exp);
         check("R10 clamp", cmd_o, (exp < 500) ? exp : 500);
         if (exp < MAXL) check("R7 still ramping", state, 2);
      end
      check("R7 saturated level", level, MAXL);
      step();
      check("R7 run after full level", state, 3);
      check("R12 drive on in run", drive_en, 1);
   endtask

   task automatic t_noload();
      cmd = 10'd50;
      #1;
      check("R10 clamp passes low command", cmd_o, 50);
      step();
      check("R11 below low threshold disables", drive_en, 0);
      cmd = 10'd110;
      step(); step();
      check("R11 inside band keeps off", drive_en, 0);
      cmd = 10'd200;
      step();
      check("R11 above high threshold enables", drive_en, 1);
      cmd = 10'd110;
      step(); step();
      check("R11 inside band keeps on", drive_en, 1);
      cmd = 10'd500;
      step();
   endtask

   task automatic t_overcurrent();
      int prev;
      bit done;
      oc = 1'b1;
      #1;
      check("R6 oc removes enable at once", drive_en, 0);
      step();
      check("R8 enter soft stop", state, 4);
      check("R8 level held on entry", level, MAXL);
      done = 1'b0;
      for (int i = 0; i < 40 && !done; i++) begin
         prev = level;
         if (i == 3) oc = 1'b0;
         step();
         if (prev >= FLR) begin
            check("R8 soft stop continues, oc ignored", state, 4);
            check("R8 down step", level, (prev < DN) ? 0 : prev - DN);
         end else begin
            check("R9 restart after floor", state, 2);
            check("R9 first ramp step", level, prev + UP);
            check("R9 floor value crossed", prev, 63);
            done = 1'b1;
         end
      end
      check("R9 soft stop ended", done, 1);
      oc = 1'b1;
      prev = level;
      step();
      oc = 1'b0;
      check("R8 oc during soft start", state, 4);
      check("R8 level held", level, prev);
      step();
      check("R9 below floor returns to soft start", state, 2);
   endtask

   task automatic t_ref_dis();
      ref_bad = 1'b1;
      #1;
      check("R6 ref bad removes enable", drive_en, 0);
      step();
      check("R4 disabled state", state, 1);
      check("R4 level cleared", level, 0);
      ref_bad = 1'b0;
      step();
      check("R7 restart from disabled", state, 2);
      step(); step();
      ext_dis = 1'b1;
      #1;
      check("R6 disable removes enable", drive_en, 0);
      step();
      check("R5 disabled state", state, 1);
      check("R5 level cleared", level, 0);
      check("R10 clamp zero when disabled", cmd_o, 0);
      ext_dis = 1'b0;
      step();
      check("R5 leaves disabled", state, 2);
   endtask

   task automatic t_uv_priority();
      for (int i = 0; i < 5; i++) step();
      ref_bad = 1'b1; oc = 1'b1; ext_dis = 1'b1; vdd_low = 1'b1;
      #1;
      check("R6 undervoltage removes enable", drive_en, 0);
      step();
      check("R3 lockout wins", state, 0);
      check("R3 level cleared", level, 0);
      ref_bad = 1'b0; oc = 1'b0; ext_dis = 1'b0; vdd_low = 1'b0;
      step(); step(); step();
      check("R2 stays in lockout without start flag", state, 0);
      vdd_start = 1'b1; vdd_low = 1'b1;
      step();
      check("R2 low flag wins over start flag", state, 0);
      vdd_low = 1'b0;
      step();
      vdd_start = 1'b0;
      check("R2 start flag releases lockout", state, 2);
      step(); step();
      check("R2 supply held good after start", state, 2);
   endtask

   initial begin
      #1;
      t_reset();
      #20;
      rst_n = 1'b1;
      t_uvlo_release();
      t_ramp();
      t_noload();
      t_overcurrent();
      t_ref_dis();
      t_uv_priority();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #1000000;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule